// File: doc/BRIEF.md
# Selectable valid-ready register slice

This block is one stage placed on a valid/ready stream to break long timing paths. Three build-time flags choose which paths are cut. With no flag set the stage is a plain wire. The forward flag registers valid and payload. The backward flag registers the ready path through a skid register. Both flags together give a skid stage followed by a forward register, so every path is cut. The half-rate flag cuts every path with a single holding register, and the stage then accepts at most one transfer in every two cycles.

The half-rate flag cannot be combined with the other two flags. Such a build stops at elaboration. In every mode the stage keeps the order of the items. It never drops an item and never repeats one. The payload width is a parameter. Everything runs on one clock with a synchronous active-high reset.

Top module: `stream_slice`

## Requirements
- R1: In the first cycle after reset, with `out_ready` high and no input offered, every mode shows `out_valid` low and `in_ready` high.
- R2: With no flag set, `out_valid` and `out_data` follow `in_valid` and `in_data` in the same cycle, and `in_ready` follows `out_ready` in the same cycle. Continuous traffic moves one item per cycle.
- R3: With only the forward flag set, an item accepted in cycle t is presented at the output in cycle t+1. `in_ready` is high when the output register is empty or `out_ready` is high, and it rises in the same cycle as `out_ready`. Continuous traffic moves one item per cycle.
- R4: With only the backward flag set, an accepted item is visible at the output in the same cycle when the skid register is empty. `in_ready` depends only on the skid register: once an item stalls, `in_ready` stays low in the next cycle even if `out_ready` is high. Continuous traffic moves one item per cycle.
- R5: With both the forward and the backward flags set, the latency is one cycle and `in_ready` is registered, so raising `out_ready` does not raise `in_ready` in the same cycle. The stage holds up to two items, and continuous traffic moves one item per cycle.
- R6: With the half-rate flag set, the latency is one cycle and `in_ready` is low in the cycle after each accepted item. Continuous traffic with `out_ready` held high moves exactly one item every two cycles.
- R7: In every mode, items leave in the order they were accepted, with no loss and no duplicates. The number of items held never exceeds the stage capacity: 0 with no flag, 1 with forward only, 1 with backward only, 2 with both, 1 with half-rate.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers an item |
| in_ready | output | 1 | Stage accepts the offered item this cycle |
| in_data | input | DATA_W | Upstream payload |
| out_valid | output | 1 | Stage offers an item downstream |
| out_ready | input | 1 | Downstream accepts the item this cycle |
| out_data | output | DATA_W | Downstream payload |

## Verification
The assertions check the following on every cycle:
- hold stability under backpressure;
- the empty output after reset;
- the dead cycle after each half-rate accept;
- that a backward-cut `in_ready` falls only after a stall;
- that occupancy, counted from input and output handshakes, stays within the capacity of the selected mode.

Some behaviours appear only in the bench scenarios, which run all five modes side by side:
- the latency of each mode;
- the throughput under continuous traffic;
- whether `in_ready` follows `out_ready` in the same cycle;
- the order of the items under mixed valid and ready patterns.

// File: rtl/slice_pkg.sv
package slice_pkg;

    typedef enum logic [2:0] {
        CUT_NONE = 3'd0,
        CUT_FWD  = 3'd1,
        CUT_BWD  = 3'd2,
        CUT_BOTH = 3'd3,
        CUT_HALF = 3'd4
    } cut_mode_e;

    // Map the three build flags onto one mode; half-rate wins when set.
    function automatic cut_mode_e pick_mode(input bit fwd, input bit bwd, input bit half);
        if (half)
            return CUT_HALF;
        else if (fwd && bwd)
            return CUT_BOTH;
        else if (fwd)
            return CUT_FWD;
        else if (bwd)
            return CUT_BWD;
        return CUT_NONE;
    endfunction

    // Number of items a stage of the given mode can hold.
    function automatic int unsigned slot_count(input cut_mode_e m);
        case (m)
            CUT_NONE: return 0;
            CUT_BOTH: return 2;
            default:  return 1;
        endcase
    endfunction

    // True when valid and payload leave the stage from a register.
    function automatic bit output_registered(input cut_mode_e m);
        return (m == CUT_FWD) || (m == CUT_BOTH) || (m == CUT_HALF);
    endfunction

endpackage

// File: rtl/fwd_stage.sv
module fwd_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    logic              held_q;
    logic [DATA_W-1:0] data_q;

    // Room when the register is empty or its item leaves this cycle.
    assign up_ready = !held_q || dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else if (up_ready) begin
            held_q <= up_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (up_valid && up_ready)
            data_q <= up_data;
    end

    assign dn_valid = held_q;
    assign dn_data  = data_q;
endmodule

// File: rtl/skid_stage.sv
module skid_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    logic              spare_q;
    logic [DATA_W-1:0] spare_data_q;

    // Ready toward upstream comes from a flop only.
    assign up_ready = !spare_q;
    assign dn_valid = up_valid || spare_q;
    assign dn_data  = spare_q ? spare_data_q : up_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            spare_q <= 1'b0;
        end else if (!spare_q && up_valid && !dn_ready) begin
            spare_q <= 1'b1;
        end else if (spare_q && dn_ready) begin
            spare_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!spare_q && up_valid && !dn_ready)
            spare_data_q <= up_data;
    end
endmodule

// File: rtl/half_stage.sv
module half_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Fill and drain never overlap, so every port is a flop output.
    assign up_ready = !full_q;
    assign dn_valid = full_q;
    assign dn_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (!full_q && up_valid) begin
            full_q <= 1'b1;
        end else if (full_q && dn_ready) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!full_q && up_valid)
            data_q <= up_data;
    end
endmodule

// File: rtl/stream_slice.sv
module stream_slice
    import slice_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter bit REG_FWD   = 1'b1,
    parameter bit REG_BWD   = 1'b1,
    parameter bit HALF_RATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam cut_mode_e MODE = pick_mode(REG_FWD, REG_BWD, HALF_RATE);

    generate
        if (HALF_RATE && (REG_FWD || REG_BWD)) begin : g_bad_flags
            $error("stream_slice: half-rate cannot be combined with other cuts");
        end

        if (MODE == CUT_NONE) begin : g_none
            assign in_ready  = out_ready;
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else if (MODE == CUT_FWD) begin : g_fwd
            fwd_stage #(.DATA_W(DATA_W)) u_fwd (
                .clk(clk), .rst(rst),
                .up_valid(in_valid), .up_ready(in_ready), .up_data(in_data),
                .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_data)
            );
        end else if (MODE == CUT_BWD) begin : g_bwd
            skid_stage #(.DATA_W(DATA_W)) u_skid (
                .clk(clk), .rst(rst),
                .up_valid(in_valid), .up_ready(in_ready), .up_data(in_data),
                .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_data)
            );
        end else if (MODE == CUT_BOTH) begin : g_both
            logic              mid_valid;
            logic              mid_ready;
            logic [DATA_W-1:0] mid_data;
            skid_stage #(.DATA_W(DATA_W)) u_skid (
                .clk(clk), .rst(rst),
                .up_valid(in_valid), .up_ready(in_ready), .up_data(in_data),
                .dn_valid(mid_valid), .dn_ready(mid_ready), .dn_data(mid_data)
            );
            fwd_stage #(.DATA_W(DATA_W)) u_fwd (
                .clk(clk), .rst(rst),
                .up_valid(mid_valid), .up_ready(mid_ready), .up_data(mid_data),
                .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_data)
            );
        end else begin : g_half
            half_stage #(.DATA_W(DATA_W)) u_half (
                .clk(clk), .rst(rst),
                .up_valid(in_valid), .up_ready(in_ready), .up_data(in_data),
                .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_data)
            );
        end
    endgenerate
endmodule

// File: rtl/slice_chk.sv
module slice_chk
    import slice_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter bit REG_FWD   = 1'b1,
    parameter bit REG_BWD   = 1'b1,
    parameter bit HALF_RATE = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    localparam cut_mode_e   MODE   = pick_mode(REG_FWD, REG_BWD, HALF_RATE);
    localparam bit          REG_OUT = output_registered(MODE);
    localparam bit          IS_HALF = (MODE == CUT_HALF);
    localparam bit          IS_BWD  = (MODE == CUT_BWD);
    localparam bit          RISE_FROM_INPUT = (MODE == CUT_FWD) || (MODE == CUT_HALF);
    localparam logic [2:0]  CAP     = 3'(slot_count(MODE));

    logic       in_fire;
    logic       out_fire;
    logic [2:0] occ_q;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst)
            occ_q <= 3'd0;
        else
            occ_q <= occ_q + 3'(in_fire) - 3'(out_fire);
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (REG_OUT && $past(rst)) |-> !out_valid);

    // R8
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R6
    half_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (IS_HALF && in_fire) |=> !in_ready);

    // R3
    fwd_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (RISE_FROM_INPUT && $rose(out_valid)) |-> $past(in_fire));

    // R4
    skid_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (IS_BWD && !in_ready) |-> ($past(in_fire && !out_ready) || $past(!in_ready && !out_ready)));

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ_q <= CAP);
endmodule

bind stream_slice slice_chk #(
    .DATA_W(DATA_W), .REG_FWD(REG_FWD), .REG_BWD(REG_BWD), .HALF_RATE(HALF_RATE)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_stream_slice.sv
module tb_stream_slice;
    localparam int W = 16;
    localparam int N = 5;
    // lane 0 none, 1 forward, 2 backward, 3 both, 4 half-rate
    localparam logic [N-1:0] L_FWD  = 5'b01010;
    localparam logic [N-1:0] L_BWD  = 5'b01100;
    localparam logic [N-1:0] L_HALF = 5'b10000;

    typedef struct packed {
        logic [15:0] offer;
        logic [15:0] rdy;
    } vec_t;

    // Stimulus rows; the expected result of each row is full, ordered delivery.
    localparam vec_t VECS [8] = '{
        '{16'hFFFF, 16'hFFFF}, '{16'hFFFF, 16'hAAAA},
        '{16'hAAAA, 16'hFFFF}, '{16'hFFFF, 16'h3333},
        '{16'h5A5A, 16'hC3C3}, '{16'hFFFF, 16'h0F0F},
        '{16'h1111, 16'hFFFF}, '{16'hF0F0, 16'h9999}
    };

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] in_valid, in_ready, out_valid, out_ready;
    logic [W-1:0] in_data [N];
    logic [W-1:0] out_data [N];

    always #5 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : lane
        stream_slice #(.DATA_W(W), .REG_FWD(L_FWD[g]), .REG_BWD(L_BWD[g]),
                       .HALF_RATE(L_HALF[g])) dut (
            .clk(clk), .rst(rst),
            .in_valid(in_valid[g]), .in_ready(in_ready[g]), .in_data(in_data[g]),
            .out_valid(out_valid[g]), .out_ready(out_ready[g]), .out_data(out_data[g])
        );
    end

    string REQ [N] = '{"R2", "R3", "R4", "R5", "R6"};

    int total = 0;
    int bad = 0;
    int tick_no = 0;
    int next_in [N];
    int exp_out [N];
    int n_acc [N];
    int n_rcv [N];
    int cnt_in [N];
    int first_in [N];
    int first_out [N];
    logic pend [N];
    logic hold [N];
    logic [W-1:0] hold_d [N];
    logic s_ir [N];
    logic s_ov [N];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic [N-1:0] offer, input logic [N-1:0] rdy);
        @(negedge clk);
        for (int l = 0; l < N; l++) begin
            if (pend[l]) begin
                in_valid[l] = 1'b0;
                pend[l] = 1'b0;
            end
            if (!in_valid[l] && offer[l]) begin
                in_valid[l] = 1'b1;
                in_data[l] = W'(next_in[l] + l * 4096);
            end
            out_ready[l] = rdy[l];
        end
        #4;
        for (int l = 0; l < N; l++) begin
            s_ir[l] = in_ready[l];
            s_ov[l] = out_valid[l];
            if (in_valid[l] && in_ready[l]) begin
                next_in[l]++;
                n_acc[l]++;
                cnt_in[l]++;
                pend[l] = 1'b1;
                if (first_in[l] < 0) first_in[l] = tick_no;
            end
            if (hold[l]) begin
                check(out_valid[l] == 1'b1, "R8", $sformatf("lane%0d valid held", l),
                      int'(out_valid[l]), 1);
                check(out_data[l] == hold_d[l], "R8", $sformatf("lane%0d data held", l),
                      int'(out_data[l]), int'(hold_d[l]));
            end
            if (out_valid[l] && out_ready[l]) begin
                check(out_data[l] == W'(exp_out[l] + l * 4096), "R7",
                      $sformatf("lane%0d order", l), int'(out_data[l]),
                      int'(W'(exp_out[l] + l * 4096)));
                exp_out[l]++;
                n_rcv[l]++;
                if (first_out[l] < 0) first_out[l] = tick_no;
            end
            hold[l] = out_valid[l] && !out_ready[l];
            hold_d[l] = out_data[l];
        end
        tick_no++;
    endtask

    task automatic drain();
        repeat (8) tick('0, '1);
        for (int l = 0; l < N; l++)
            check(n_acc[l] == n_rcv[l], "R7", $sformatf("lane%0d delivered all", l),
                  n_rcv[l], n_acc[l]);
    endtask

    task automatic clear_marks();
        for (int l = 0; l < N; l++) begin
            cnt_in[l] = 0;
            first_in[l] = -1;
            first_out[l] = -1;
        end
    endtask

    initial begin
        #(200000 * 10);
        check(1'b0, "R7", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int exp_cnt;
        int exp_lat;
        logic exp_ir;
        rst = 1'b1;
        in_valid = '0;
        out_ready = '1;
        for (int l = 0; l < N; l++) begin
            in_data[l] = '0;
            next_in[l] = 0; exp_out[l] = 0; n_acc[l] = 0; n_rcv[l] = 0;
            pend[l] = 1'b0; hold[l] = 1'b0; hold_d[l] = '0;
        end
        clear_marks();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        tick('0, '1);
        for (int l = 0; l < N; l++) begin
            check(s_ov[l] == 1'b0, "R1", $sformatf("lane%0d out_valid after reset", l),
                  int'(s_ov[l]), 0);
            check(s_ir[l] == 1'b1, "R1", $sformatf("lane%0d in_ready after reset", l),
                  int'(s_ir[l]), 1);
        end

        // Vector table walk: R7 ordering and R8 stability under mixed patterns
        for (int v = 0; v < 8; v++) begin
            for (int c = 0; c < 16; c++)
                tick({N{VECS[v].offer[c]}}, {N{VECS[v].rdy[c]}});
            drain();
        end

        // Throughput and latency under continuous traffic (R2..R6)
        clear_marks();
        tick_no = 0;
        repeat (20) tick('1, '1);
        for (int l = 0; l < N; l++) begin
            exp_cnt = L_HALF[l] ? 10 : 20;
            exp_lat = (L_FWD[l] || L_HALF[l]) ? 1 : 0;
            check(cnt_in[l] == exp_cnt, REQ[l], $sformatf("lane%0d accepts in 20 cycles", l),
                  cnt_in[l], exp_cnt);
            check(first_out[l] - first_in[l] == exp_lat, REQ[l],
                  $sformatf("lane%0d latency", l), first_out[l] - first_in[l], exp_lat);
        end
        drain();

        // Ready path: fill under stall, then raise out_ready (R2..R6)
        repeat (4) tick('1, '0);
        for (int l = 0; l < N; l++)
            check(s_ir[l] == 1'b0, REQ[l], $sformatf("lane%0d in_ready while stalled", l),
                  int'(s_ir[l]), 0);
        tick('1, '1);
        for (int l = 0; l < N; l++) begin
            exp_ir = (l < 2) ? 1'b1 : 1'b0;
            check(s_ir[l] == exp_ir, REQ[l], $sformatf("lane%0d in_ready on release", l),
                  int'(s_ir[l]), int'(exp_ir));
        end
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule